// File: doc/BRIEF.md
# NAND Flash Page Program Sequencer

This block takes one page-write request and turns it into the complete pin-level write of a single SLC NAND die with an 8-bit bus. After a request is accepted, it selects the die and sends the program-setup command. Five address bytes follow. The sequencer then holds the bus idle for the address-to-data gap and streams the page bytes, which it pulls one at a time from an upstream show-ahead read port. Last comes the confirm command.

During the internal programming time it waits on the ready/busy line, never on a fixed delay. When the line rises, it sends the status command, reads the status byte and reports the result with a one-cycle completion pulse and a pass/fail flag. A watchdog limits the busy wait, and the run ends as a failure if the die never becomes ready.

One flash bus cycle takes two system clocks. The write strobe is low in the first clock and high in the second, and the die latches on the rising strobe. A system clock of about 64 MHz therefore gives a derated flash bus of 32 MHz. The default gap of 6 clocks is 3 bus periods, which covers the 70 ns minimum. Page size, gap, busy limit and the read-strobe timings are parameters.

Top module: `nandProgSeq`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high (inactive), the command-latch and address-latch pins are low, the bus driver is off, and done is low.
- R2: A request is taken only when the block is idle. `startAck` pulses for exactly one clock per accepted request, and a request held during an operation gets no acknowledge and causes no bus activity.
- R3: Every bus write is one clock with `weN` low followed by a rising edge. Commands are latched with `cle`=1 and `ale`=0. The order of latched items is: command 0x80, five address bytes, the page data, command 0x10, and then, when the die became ready, command 0x70.
- R4: Address bytes are latched with `ale`=1 and `cle`=0, in this order: colAddr[7:0], colAddr[15:8], rowAddr[7:0], rowAddr[15:8], rowAddr[23:16].
- R5: Between the rising strobe of the last address byte and the falling strobe of the first data byte, `weN` stays high for at least ADL_CLKS clocks.
- R6: Exactly PAGE_BYTES data bytes are latched with `cle`=`ale`=0. Byte k equals the k-th value on `rdData`, and `rdReq` pulses once per byte, in the same clock that `rdData` is taken.
- R7: After command 0x10 the block ignores `rbN` for WB_CLKS clocks and then waits for `rbN`=1. The status command is latched only after `rbN` has returned high.
- R8: After command 0x70 and WHR_CLKS clocks, `reN` goes low for RE_CLKS clocks with the bus driver off. Bit 0 of `ioIn` sampled at the end of that window becomes `fail` (1 = program failed).
- R9: `done` is a one-clock pulse. In that clock `ceN` is high and `fail` is valid, and `fail` holds its value until the next accepted request.
- R10: If `rbN` stays low for BUSY_LIMIT clocks after the ignore window, the block ends with `done` and `fail`=1 and latches no status command.
- R11: `cle` and `ale` are never high together, and `weN` is low only while `ceN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (two clocks per flash bus cycle) |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to program one page |
| startAck | output | 1 | One-clock acknowledge of an accepted request |
| colAddr | input | 16 | Column address, captured at acceptance |
| rowAddr | input | 24 | Row (page) address, captured at acceptance |
| rdReq | output | 1 | Pops one byte from the upstream show-ahead port |
| rdData | input | 8 | Current head byte of the upstream port |
| ceN | output | 1 | Flash chip enable, active low |
| cle | output | 1 | Flash command latch enable |
| ale | output | 1 | Flash address latch enable |
| weN | output | 1 | Flash write strobe, active low |
| reN | output | 1 | Flash read strobe, active low |
| ioOut | output | 8 | Flash I/O bus, value driven |
| ioOe | output | 1 | Flash I/O bus output enable |
| ioIn | input | 8 | Flash I/O bus, value read |
| rbN | input | 1 | Flash ready (1) / busy (0) |
| done | output | 1 | One-clock completion pulse |
| fail | output | 1 | Result of the last operation, 1 = failed |

## Verification
The hardest cases to reach from the ports are the ready/busy corners. One is a die that raises `rbN` almost at once, while the sequencer is still ignoring it. The other is a die that never becomes ready, which has to end in the watchdog path with no status command. The bench models the die's busy line directly from its scoreboard monitor. It drops `rbN` once it sees the confirm command latched, then releases it after a chosen number of clocks: one clock, a long time, or never. It also issues a request in the middle of the busy wait to show that the request is ignored.

// File: rtl/npsPkg.sv
package npsPkg;
  localparam logic [7:0] CMD_SETUP   = 8'h80;
  localparam logic [7:0] CMD_CONFIRM = 8'h10;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam int ADDR_BYTES = 5;

  typedef enum logic [2:0] {
    SEL_SETUP, SEL_CONFIRM, SEL_STATUS, SEL_ADDR, SEL_DATA
  } busSel_e;

  typedef struct packed {
    logic    busCyc;    // start one bus write (weN low this coming clock)
    busSel_e sel;       // what to put on the bus
    logic    accept;    // capture request, select die, acknowledge
    logic    cntClr;    // restart the shared timer
    logic    idxClr;    // restart the byte index
    logic    idxInc;    // advance the byte index
    logic    reLow;     // open the status read window
    logic    reHigh;    // close the status read window, capture status
    logic    timeout;   // busy watchdog expired
    logic    finish;    // release die, pulse done
  } npsStrobe_t;
endpackage

// File: rtl/npsCtrl.sv
module npsCtrl
  import npsPkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int ADL_CLKS   = 6,
  parameter int WB_CLKS    = 4,
  parameter int BUSY_LIMIT = 65536,
  parameter int WHR_CLKS   = 4,
  parameter int RE_CLKS    = 2,
  parameter int CW         = 17,
  parameter int IW         = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic          rbN,
  input  logic [CW-1:0] cnt,
  input  logic [IW-1:0] idx,
  output npsStrobe_t    strobe
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_ADDR, ST_GAP, ST_DATA, ST_CONFIRM,
    ST_BLIND, ST_BUSY, ST_STATUS, ST_TURN, ST_READ, ST_FIN
  } state_e;

  state_e state, stateNext;
  logic   phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= 1'b0;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
    end
  end

  always_comb begin
    stateNext = state;
    phaseNext = phase;
    strobe    = '0;
    strobe.sel = SEL_SETUP;
    unique case (state)
      ST_IDLE: begin
        phaseNext = 1'b0;
        if (startReq) begin
          strobe.accept = 1'b1;
          stateNext = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (!phase) begin
          strobe.busCyc = 1'b1;
          strobe.sel = SEL_SETUP;
          phaseNext = 1'b1;
        end else begin
          phaseNext = 1'b0;
          strobe.idxClr = 1'b1;
          stateNext = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (!phase) begin
          strobe.busCyc = 1'b1;
          strobe.sel = SEL_ADDR;
          phaseNext = 1'b1;
        end else begin
          phaseNext = 1'b0;
          if (idx == IW'(ADDR_BYTES - 1)) begin
            strobe.cntClr = 1'b1;
            stateNext = ST_GAP;
          end else begin
            strobe.idxInc = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (cnt == CW'(ADL_CLKS - 1)) begin
          strobe.idxClr = 1'b1;
          stateNext = ST_DATA;
        end
      end
      ST_DATA: begin
        if (!phase) begin
          strobe.busCyc = 1'b1;
          strobe.sel = SEL_DATA;
          phaseNext = 1'b1;
        end else begin
          phaseNext = 1'b0;
          if (idx == IW'(PAGE_BYTES - 1)) stateNext = ST_CONFIRM;
          else strobe.idxInc = 1'b1;
        end
      end
      ST_CONFIRM: begin
        if (!phase) begin
          strobe.busCyc = 1'b1;
          strobe.sel = SEL_CONFIRM;
          phaseNext = 1'b1;
        end else begin
          phaseNext = 1'b0;
          strobe.cntClr = 1'b1;
          stateNext = ST_BLIND;
        end
      end
      ST_BLIND: begin
        if (cnt == CW'(WB_CLKS - 1)) begin
          strobe.cntClr = 1'b1;
          stateNext = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (rbN) begin
          stateNext = ST_STATUS;
        end else if (cnt == CW'(BUSY_LIMIT - 1)) begin
          strobe.timeout = 1'b1;
          stateNext = ST_FIN;
        end
      end
      ST_STATUS: begin
        if (!phase) begin
          strobe.busCyc = 1'b1;
          strobe.sel = SEL_STATUS;
          phaseNext = 1'b1;
        end else begin
          phaseNext = 1'b0;
          strobe.cntClr = 1'b1;
          stateNext = ST_TURN;
        end
      end
      ST_TURN: begin
        if (cnt == CW'(WHR_CLKS - 1)) begin
          strobe.reLow = 1'b1;
          strobe.cntClr = 1'b1;
          stateNext = ST_READ;
        end
      end
      ST_READ: begin
        if (cnt == CW'(RE_CLKS - 1)) begin
          strobe.reHigh = 1'b1;
          stateNext = ST_FIN;
        end
      end
      ST_FIN: begin
        strobe.finish = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R2
  accept_only_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |-> (state == ST_IDLE && startReq));
  // R7
  busy_no_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BLIND || state == ST_BUSY) |-> !strobe.busCyc);
endmodule

// File: rtl/npsDatapath.sv
module npsDatapath
  import npsPkg::*;
#(
  parameter int CW = 17,
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  npsStrobe_t    strobe,
  input  logic [15:0]   colAddr,
  input  logic [23:0]   rowAddr,
  input  logic [7:0]    rdData,
  input  logic [7:0]    ioIn,
  output logic [CW-1:0] cnt,
  output logic [IW-1:0] idx,
  output logic          rdReq,
  output logic          startAck,
  output logic          ceN,
  output logic          cle,
  output logic          ale,
  output logic          weN,
  output logic          reN,
  output logic [7:0]    ioOut,
  output logic          ioOe,
  output logic          done,
  output logic          fail
);
  logic [39:0] addrQ;
  logic [7:0]  addrByte;
  logic [7:0]  busByte;

  assign rdReq = strobe.busCyc && (strobe.sel == SEL_DATA);

  always_comb begin
    unique case (idx[2:0])
      3'd0:    addrByte = addrQ[7:0];
      3'd1:    addrByte = addrQ[15:8];
      3'd2:    addrByte = addrQ[23:16];
      3'd3:    addrByte = addrQ[31:24];
      default: addrByte = addrQ[39:32];
    endcase
  end

  always_comb begin
    unique case (strobe.sel)
      SEL_SETUP:   busByte = CMD_SETUP;
      SEL_CONFIRM: busByte = CMD_CONFIRM;
      SEL_STATUS:  busByte = CMD_STATUS;
      SEL_ADDR:    busByte = addrByte;
      default:     busByte = rdData;
    endcase
  end

  // shared timer and byte index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      idx <= '0;
    end else begin
      cnt <= strobe.cntClr ? '0 : cnt + 1'b1;
      if (strobe.idxClr) idx <= '0;
      else if (strobe.idxInc) idx <= idx + 1'b1;
    end
  end

  // flash pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceN   <= 1'b1;
      cle   <= 1'b0;
      ale   <= 1'b0;
      weN   <= 1'b1;
      reN   <= 1'b1;
      ioOut <= '0;
      ioOe  <= 1'b0;
    end else begin
      if (strobe.accept) ceN <= 1'b0;
      else if (strobe.finish) ceN <= 1'b1;

      if (strobe.busCyc) begin
        weN   <= 1'b0;
        ioOut <= busByte;
        ioOe  <= 1'b1;
        cle   <= (strobe.sel != SEL_ADDR) && (strobe.sel != SEL_DATA);
        ale   <= (strobe.sel == SEL_ADDR);
      end else begin
        weN <= 1'b1;
        if (weN) begin
          cle <= 1'b0;
          ale <= 1'b0;
        end
      end

      if (strobe.reLow) begin
        reN  <= 1'b0;
        ioOe <= 1'b0;
      end else if (strobe.reHigh) begin
        reN <= 1'b1;
      end
      if (strobe.finish) ioOe <= 1'b0;
    end
  end

  // request capture and result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      startAck <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      startAck <= strobe.accept;
      done     <= strobe.finish;
      if (strobe.accept) begin
        addrQ <= {rowAddr, colAddr};
        fail  <= 1'b0;
      end
      if (strobe.timeout) fail <= 1'b1;
      else if (strobe.reHigh) fail <= ioIn[0];
    end
  end

  // R11
  latch_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale));
  // R11
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !ceN);
  // R3
  we_low_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    !weN |=> weN);
  // R8
  re_bus_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reN |-> !ioOe);
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    startAck |=> !startAck);
endmodule

// File: rtl/nandProgSeq.sv
module nandProgSeq
  import npsPkg::*;
#(
  parameter int PAGE_BYTES = 2048,
  parameter int ADL_CLKS   = 6,
  parameter int WB_CLKS    = 4,
  parameter int BUSY_LIMIT = 65536,
  parameter int WHR_CLKS   = 4,
  parameter int RE_CLKS    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  output logic        startAck,
  input  logic [15:0] colAddr,
  input  logic [23:0] rowAddr,
  output logic        rdReq,
  input  logic [7:0]  rdData,
  output logic        ceN,
  output logic        cle,
  output logic        ale,
  output logic        weN,
  output logic        reN,
  output logic [7:0]  ioOut,
  output logic        ioOe,
  input  logic [7:0]  ioIn,
  input  logic        rbN,
  output logic        done,
  output logic        fail
);
  localparam int WAIT_MAX1 = (ADL_CLKS > WB_CLKS) ? ADL_CLKS : WB_CLKS;
  localparam int WAIT_MAX2 = (WHR_CLKS > RE_CLKS) ? WHR_CLKS : RE_CLKS;
  localparam int WAIT_MAX3 = (WAIT_MAX1 > WAIT_MAX2) ? WAIT_MAX1 : WAIT_MAX2;
  localparam int CNT_MAX   = (BUSY_LIMIT > WAIT_MAX3) ? BUSY_LIMIT : WAIT_MAX3;
  localparam int CW        = $clog2(CNT_MAX + 1);
  localparam int IDX_MAX   = (PAGE_BYTES > ADDR_BYTES) ? PAGE_BYTES : ADDR_BYTES;
  localparam int IW        = (IDX_MAX > 8) ? $clog2(IDX_MAX) : 3;

  npsStrobe_t    strobe;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;

  npsCtrl #(
    .PAGE_BYTES(PAGE_BYTES), .ADL_CLKS(ADL_CLKS), .WB_CLKS(WB_CLKS),
    .BUSY_LIMIT(BUSY_LIMIT), .WHR_CLKS(WHR_CLKS), .RE_CLKS(RE_CLKS),
    .CW(CW), .IW(IW)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .rbN(rbN),
    .cnt(cnt), .idx(idx), .strobe(strobe)
  );

  npsDatapath #(.CW(CW), .IW(IW)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .colAddr(colAddr), .rowAddr(rowAddr), .rdData(rdData), .ioIn(ioIn),
    .cnt(cnt), .idx(idx), .rdReq(rdReq), .startAck(startAck),
    .ceN(ceN), .cle(cle), .ale(ale), .weN(weN), .reN(reN),
    .ioOut(ioOut), .ioOe(ioOe), .done(done), .fail(fail)
  );
endmodule

// File: tb/test_nandProgSeq.sv
module test_nandProgSeq;
  localparam int PG   = 8;
  localparam int ADL  = 6;
  localparam int WB   = 4;
  localparam int BLIM = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [15:0] colAddr = '0;
  logic [23:0] rowAddr = '0;
  logic [7:0] rdData, ioIn, ioOut;
  logic rbN = 1'b1;
  logic startAck, rdReq, ceN, cle, ale, weN, reN, ioOe, done, fail;

  always #5 clk = ~clk;

  nandProgSeq #(.PAGE_BYTES(PG), .ADL_CLKS(ADL), .WB_CLKS(WB),
                .BUSY_LIMIT(BLIM), .WHR_CLKS(4), .RE_CLKS(2)) i_nandProgSeq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startAck(startAck),
    .colAddr(colAddr), .rowAddr(rowAddr), .rdReq(rdReq), .rdData(rdData),
    .ceN(ceN), .cle(cle), .ale(ale), .weN(weN), .reN(reN),
    .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn), .rbN(rbN),
    .done(done), .fail(fail)
  );

  int errors = 0;
  int checks = 0;
  logic [7:0] pageBuf [PG];
  int rdPtr = 0;
  logic [7:0] statusByte = 8'h00;
  logic [9:0] expQ [$];
  bit gotConfirm = 0;
  bit busyOver = 0;
  bit prevWe = 1'b1;
  bit lastAddr = 0;
  int highCnt = 0;
  int ackCnt = 0;

  assign rdData = pageBuf[rdPtr % PG];
  assign ioIn = reN ? 8'h00 : statusByte;

  always @(posedge clk) if (rdReq) rdPtr <= rdPtr + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected item per rising write strobe
  always @(negedge clk) begin
    if (rstN) begin
      if (startAck) ackCnt++;
      if (!prevWe && weN) begin
        if (expQ.size() == 0) begin
          chk(0, "R3", "unexpected bus latch", {cle, ale, ioOut}, 0);
        end else begin
          logic [9:0] e;
          e = expQ.pop_front();
          chk({cle, ale, ioOut} == e, e[8] ? "R4" : (e[9] ? "R3" : "R6"),
              "latched {cle,ale,io}", {cle, ale, ioOut}, e);
        end
        if (cle && ioOut == 8'h10) gotConfirm = 1;
        if (cle && ioOut == 8'h70)
          chk(rbN && busyOver, "R7", "status cmd before ready", rbN, 1);
        lastAddr = ale;
      end
      if (prevWe && !weN) begin
        if (lastAddr && !ale && !cle)
          chk(highCnt >= ADL, "R5", "address-to-data gap clocks", highCnt, ADL);
        highCnt = 0;
      end else if (weN) begin
        highCnt++;
      end
      prevWe = weN;
    end
  end

  task automatic runProg(input logic [15:0] col, input logic [23:0] row,
                         input int busyLen, input bit hang,
                         input logic [7:0] stat, input bit probeStart);
    int ptr0;
    int acks0;
    for (int k = 0; k < PG; k++) pageBuf[k] = 8'(row[7:0] + 8'(k * 37) + 8'h5);
    expQ.push_back({2'b10, 8'h80});
    expQ.push_back({2'b01, col[7:0]});
    expQ.push_back({2'b01, col[15:8]});
    expQ.push_back({2'b01, row[7:0]});
    expQ.push_back({2'b01, row[15:8]});
    expQ.push_back({2'b01, row[23:16]});
    for (int k = 0; k < PG; k++) expQ.push_back({2'b00, pageBuf[k]});
    expQ.push_back({2'b10, 8'h10});
    if (!hang) expQ.push_back({2'b10, 8'h70});
    statusByte = stat;
    gotConfirm = 0;
    busyOver = 0;
    ptr0 = rdPtr;
    acks0 = ackCnt;
    @(negedge clk);
    colAddr = col;
    rowAddr = row;
    startReq = 1'b1;
    do @(negedge clk); while (!startAck);
    startReq = 1'b0;
    while (!gotConfirm) @(negedge clk);
    rbN = 1'b0;
    if (probeStart) begin
      startReq = 1'b1;
      repeat (10) @(negedge clk);
      startReq = 1'b0;
    end
    if (!hang) begin
      repeat (busyLen) @(negedge clk);
      busyOver = 1;
      rbN = 1'b1;
    end
    while (!done) @(negedge clk);
    chk(fail == (hang ? 1'b1 : stat[0]), hang ? "R10" : "R8", "fail at done",
        fail, hang ? 1 : stat[0]);
    chk(ceN == 1'b1, "R9", "ceN at done", ceN, 1);
    chk(expQ.size() == 0, hang ? "R10" : "R3", "items left", expQ.size(), 0);
    chk(rdPtr - ptr0 == PG, "R6", "rdReq pulses", rdPtr - ptr0, PG);
    chk(ackCnt - acks0 == 1, "R2", "acks per operation", ackCnt - acks0, 1);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", done, 0);
    repeat (5) @(negedge clk);
    chk(fail == (hang ? 1'b1 : stat[0]), "R9", "fail held", fail,
        hang ? 1 : stat[0]);
    rbN = 1'b1;
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ceN && weN && reN, "R1", "strobes after reset", {ceN, weN, reN}, 3'b111);
    chk(!cle && !ale && !ioOe && !done, "R1", "latches/oe/done after reset",
        {cle, ale, ioOe, done}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(ceN && !startAck, "R1", "idle after release", {ceN, startAck}, 2'b10);
    // pass, long busy
    runProg(16'h1A2B, 24'h3C4D5E, 60, 0, 8'hE0, 0);
    // fail status bit, request probed during busy (R2)
    runProg(16'h0F01, 24'hA0B1C2, 40, 0, 8'hC1, 1);
    // die ready almost at once: blind window (R7)
    runProg(16'hFFFF, 24'h000001, 1, 0, 8'h40, 0);
    // die never ready: watchdog (R10)
    runProg(16'h0000, 24'h7F7F7F, 0, 1, 8'h00, 0);
    // recovery after timeout: fail cleared by next pass
    runProg(16'h1234, 24'h567890, 25, 0, 8'h00, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule